// File: doc/BRIEF.md
# Serial Configuration Port for an Eight-Channel Receive Front End

This block receives a 40-bit configuration frame on a slow serial clock and data line, holds the last accepted frame in a configuration register, and decodes that register into the control and routing outputs for an eight-channel analog front end. A frame always begins with a 1 bit. The second bit picks write or read. Only a write frame replaces the held configuration. A read frame passes through the shift path and leaves the held register as it was.

The serial clock and data are brought into the system clock domain through synchronizer flops. A falling-edge detector produces one shift strobe for each serial clock fall. A data output continuously shows the shift buffer, never the held register, so a controller can clock a frame back out while it sends the next one. Each channel's 4-bit routing code becomes a ten-bit one-hot select for the summing outputs and a separate flag that ties the channel to the supply.

Top module: `cfgp_top`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the held configuration takes its defaults: the control byte D7..D0 = 0010_0011, so `tgc_mode`=1, `pwr_down`=0, `bw_wide`=0, `clamp_off`=0, `gain_code`=00, every routing code is 0, and the shift buffer is cleared, which puts `ser_dout` at 0.
- R2: When no frame is in progress, a falling `ser_clk` edge that carries a 0 on `ser_din` is ignored. It does not shift the buffer, does not start a frame and does not change `ser_dout`.
- R3: A frame starts on a falling edge that captures a 1 (bit D0) and holds exactly 40 bits, sent D0 first. On a write (D1 = 1), the whole frame replaces the held configuration after the 40th falling edge and not before.
- R4: A frame with D1 = 0 is a read: it shifts through the buffer, but the held configuration keeps its previous contents.
- R5: Control field positions: D2 drives `pwr_down`, D3 drives `bw_wide` (1 = wider filter), D4 drives `clamp_off` (1 = clamp transparent), D5 drives `tgc_mode` (1 = gain-ramp mode, 0 = continuous-wave mode), and D7:D6 drive `gain_code`.
- R6: Channel n (0-based, 0..7) owns frame bits D(8+4n)..D(11+4n), LSB first, shown on `route_code[4n+3:4n]`. A code c from 0 to 9 sets only bit c of that channel's slice `route_onehot[10n+9:10n]` and clears `route_tie[n]`.
- R7: A routing code from 10 to 15 sets `route_tie[n]` and clears the channel's whole one-hot slice.
- R8: `ser_dout` shows bit 0 of the shift buffer. The buffer shifts toward bit 0, so after a complete frame it shows D0, and after k further shifts it shows bit D(k) of that earlier frame. This holds the same way whether the earlier frame was a write or a read.
- R9: While `cfg_rst` is high (after synchronization), the held configuration stays at the R1 defaults, an incoming frame is discarded, and no frame progress is kept. Once `cfg_rst` is low, the next frame is accepted normally.
- R10: Between frame completions, the held configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low system reset |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_din | input | 1 | Serial data input, LSB first |
| cfg_rst | input | 1 | Active-high configuration reset (asynchronous pin, synchronized inside) |
| ser_dout | output | 1 | Serial data output: bit 0 of the shift buffer |
| pwr_down | output | 1 | Power-down enable |
| bw_wide | output | 1 | Filter bandwidth select, 1 = wider |
| clamp_off | output | 1 | 1 = output clamp transparent |
| tgc_mode | output | 1 | 1 = gain-ramp mode, 0 = continuous-wave mode |
| gain_code | output | 2 | Post-amplifier gain step code |
| route_code | output | 32 | Raw 4-bit routing code per channel |
| route_onehot | output | 80 | Ten one-hot output selects per channel |
| route_tie | output | 8 | Per-channel supply-tie flag |

## Verification
The bench builds the block with its default parameters: eight channels, 4-bit codes, ten summing outputs and two synchronizer stages. With these values the full frame length of 40 bits can be checked, the decode can be driven through every code from 0 to 15, including the six supply-tie codes, and the bench can check the serial output bit by bit against an earlier frame. A serial clock of eight system cycles keeps the synchronizer and edge-detector latency inside each serial half period, so results can be checked at a fixed point after each edge.

// File: rtl/cfgp_pkg.sv
// Package: frame layout constants shared by the configuration port.
// Assumes the control byte occupies the first eight bits of every frame.
package cfgp_pkg;
    localparam int CTRL_W    = 8;
    localparam int START_BIT = 0;
    localparam int RW_BIT    = 1;
    localparam int PD_BIT    = 2;
    localparam int BW_BIT    = 3;
    localparam int CLAMP_BIT = 4;
    localparam int MODE_BIT  = 5;
    localparam int GAIN_LSB  = 6;
    localparam int GAIN_W    = 2;
    localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 8'b0010_0011;
endpackage

// File: rtl/cfgp_sync.sv
// Module: multi-stage synchronizer for a bundle of slow asynchronous inputs.
// Assumes each input stays stable for several system clocks between changes.
module cfgp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_frame_rx.sv
// Module: serial frame receiver. It detects serial clock falls, waits for a
// start bit of 1, shifts FRAME_W bits in LSB first, and pulses frame_done for
// one cycle once the buffer holds a complete frame.
// Assumes synchronized inputs and at least two system cycles per serial half period.
module cfgp_frame_rx #(
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               s_clk,
    input  logic               s_din,
    output logic [FRAME_W-1:0] shreg,
    output logic               frame_done
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic             clk_prev;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             strobe;

    assign strobe = clk_prev & ~s_clk;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= s_clk;
    end

    // Shift buffer: a new bit enters at the top and the buffer moves toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (strobe && !hold && (active || s_din)) begin
            shreg <= {s_din, shreg[FRAME_W-1:1]};
        end
    end

    // Frame tracking: start on a 1, count bits, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            active     <= 1'b0;
            cnt        <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (strobe) begin
                if (active) begin
                    if (cnt == LAST) begin
                        active     <= 1'b0;
                        cnt        <= '0;
                        frame_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (s_din) begin
                    active <= 1'b1;
                    cnt    <= CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cfgp_route_dec.sv
// Module: decodes one channel's routing code into a one-hot output select,
// or a supply-tie flag for codes at or above NUM_OUTS.
// Assumes NUM_OUTS <= 2**CODE_W.
module cfgp_route_dec #(
    parameter int CODE_W   = 4,
    parameter int NUM_OUTS = 10
) (
    input  logic [CODE_W-1:0]   code,
    output logic [NUM_OUTS-1:0] onehot,
    output logic                tie
);
    // Compare the code with each output index.
    always_comb begin
        for (int i = 0; i < NUM_OUTS; i++) onehot[i] = (code == CODE_W'(i));
        tie = ({1'b0, code} >= (CODE_W+1)'(NUM_OUTS));
    end
endmodule

// File: rtl/cfgp_top.sv
// Module: serial configuration port top. It synchronizes the serial pins,
// receives frames, commits write frames to the held configuration, and decodes
// the control fields and per-channel routing codes.
// Assumes clk runs at least four times faster than ser_clk.
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CODE_W      = 4,
    parameter int NUM_OUTS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_clk,
    input  logic                         ser_din,
    input  logic                         cfg_rst,
    output logic                         ser_dout,
    output logic                         pwr_down,
    output logic                         bw_wide,
    output logic                         clamp_off,
    output logic                         tgc_mode,
    output logic [GAIN_W-1:0]            gain_code,
    output logic [NUM_CH*CODE_W-1:0]     route_code,
    output logic [NUM_CH*NUM_OUTS-1:0]   route_onehot,
    output logic [NUM_CH-1:0]            route_tie
);
    localparam int ROUTE_W = NUM_CH * CODE_W;
    localparam int FRAME_W = CTRL_W + ROUTE_W;
    localparam logic [FRAME_W-1:0] CFG_DEFAULT = {{ROUTE_W{1'b0}}, CTRL_DEFAULT};

    logic               s_clk, s_din, rst_hold;
    logic [FRAME_W-1:0] frame_data;
    logic               frame_done;
    logic [FRAME_W-1:0] cfg_q;

    cfgp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cfg_rst, ser_din, ser_clk}),
        .sync_out ({rst_hold, s_din, s_clk})
    );

    cfgp_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (rst_hold),
        .s_clk      (s_clk),
        .s_din      (s_din),
        .shreg      (frame_data),
        .frame_done (frame_done)
    );

    // Held configuration: defaults under either reset, replaced by write frames.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_hold)                  cfg_q <= CFG_DEFAULT;
        else if (frame_done && frame_data[RW_BIT]) cfg_q <= frame_data;
    end

    assign ser_dout   = frame_data[0];
    assign pwr_down   = cfg_q[PD_BIT];
    assign bw_wide    = cfg_q[BW_BIT];
    assign clamp_off  = cfg_q[CLAMP_BIT];
    assign tgc_mode   = cfg_q[MODE_BIT];
    assign gain_code  = cfg_q[GAIN_LSB +: GAIN_W];
    assign route_code = cfg_q[CTRL_W +: ROUTE_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cfgp_route_dec #(.CODE_W(CODE_W), .NUM_OUTS(NUM_OUTS)) u_dec (
            .code   (route_code[c*CODE_W +: CODE_W]),
            .onehot (route_onehot[c*NUM_OUTS +: NUM_OUTS]),
            .tie    (route_tie[c])
        );
    end
endmodule

// File: rtl/cfgp_checker.sv
// Module: assertion checker for cfgp_top, attached through bind.
// Assumes it observes the top's internal frame and configuration signals.
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_OUTS = 10,
    parameter int FRAME_W  = 40
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rst_hold,
    input logic                       frame_done,
    input logic [FRAME_W-1:0]         frame_data,
    input logic [FRAME_W-1:0]         cfg_q,
    input logic [NUM_CH*NUM_OUTS-1:0] route_onehot,
    input logic [NUM_CH-1:0]          route_tie
);
    localparam logic [FRAME_W-1:0] CFG_DEFAULT = {{(FRAME_W-CTRL_W){1'b0}}, CTRL_DEFAULT};

    a_r9_hold_default: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold |=> cfg_q == CFG_DEFAULT);

    a_r3_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> frame_data[START_BIT]);

    a_r3_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_data[RW_BIT] && !rst_hold) |=> cfg_q == $past(frame_data));

    a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_data[RW_BIT] && !rst_hold) |=> $stable(cfg_q));

    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !rst_hold) |=> $stable(cfg_q));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            !route_tie[c] |-> $countones(route_onehot[c*NUM_OUTS +: NUM_OUTS]) == 1);
        a_r7_tie_silent: assert property (@(posedge clk) disable iff (!rst_n)
            route_tie[c] |-> route_onehot[c*NUM_OUTS +: NUM_OUTS] == '0);
    end
endmodule

bind cfgp_top cfgp_checker #(
    .NUM_CH   (NUM_CH),
    .NUM_OUTS (NUM_OUTS),
    .FRAME_W  (FRAME_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_hold     (rst_hold),
    .frame_done   (frame_done),
    .frame_data   (frame_data),
    .cfg_q        (cfg_q),
    .route_onehot (route_onehot),
    .route_tie    (route_tie)
);

// File: tb/cfgp_top_tb.sv
// Directed bench for cfgp_top: one task per scenario, each checking its own results.
module cfgp_top_tb;
    localparam int NCH = 8, CW = 4, NO = 10, FW = 40;
    localparam logic [7:0] CTRL_DEF = 8'b0010_0011;

    logic clk = 1'b0, rst_n = 1'b0, ser_clk = 1'b1, ser_din = 1'b0, cfg_rst = 1'b0;
    logic ser_dout, pwr_down, bw_wide, clamp_off, tgc_mode;
    logic [1:0] gain_code;
    logic [NCH*CW-1:0] route_code;
    logic [NCH*NO-1:0] route_onehot;
    logic [NCH-1:0] route_tie;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfgp_top u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .cfg_rst(cfg_rst),
        .ser_dout(ser_dout), .pwr_down(pwr_down), .bw_wide(bw_wide), .clamp_off(clamp_off),
        .tgc_mode(tgc_mode), .gain_code(gain_code), .route_code(route_code),
        .route_onehot(route_onehot), .route_tie(route_tie)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: data set while the clock is high, taken on the fall.
    task automatic send_bit(input logic b);
        ser_din = b; ser_clk = 1'b1; wait_clk(4);
        ser_clk = 1'b0; wait_clk(4);
    endtask

    task automatic send_frame(input logic [FW-1:0] f);
        for (int i = 0; i < FW; i++) send_bit(f[i]);
        ser_clk = 1'b1; wait_clk(6);
    endtask

    // Compare every output against the decode of an expected frame (R5, R6, R7).
    task automatic check_cfg(input string tag, input logic [FW-1:0] e);
        logic [NCH*NO-1:0] oh = '0;
        logic [NCH-1:0] tie = '0;
        for (int c = 0; c < NCH; c++) begin
            int code = int'(e[8 + c*CW +: CW]);
            if (code < NO) oh[c*NO + code] = 1'b1;
            else           tie[c] = 1'b1;
        end
        chk({tag, " R5 ctrl"}, {pwr_down, bw_wide, clamp_off, tgc_mode, gain_code},
            {e[2], e[3], e[4], e[5], e[7:6]});
        chk({tag, " R6 code"}, route_code, e[FW-1:8]);
        chk({tag, " R6 onehot"}, route_onehot, oh);
        chk({tag, " R7 tie"}, route_tie, tie);
    endtask

    localparam logic [FW-1:0] DEF_FRAME = {32'h0, CTRL_DEF};
    localparam logic [FW-1:0] W1 = {32'h7654_3210, 8'b1001_1111};
    localparam logic [FW-1:0] W2 = {32'h1234_5689, 8'b0110_0011};
    localparam logic [FW-1:0] RD = {32'h9999_9999, 8'b1111_1101};
    localparam logic [FW-1:0] W3 = {32'hFEDC_BA9A, 8'b1100_1011};
    localparam logic [FW-1:0] RA = {32'h0F1E_2D3C, 8'b0101_1001};

    task automatic t_reset_defaults;
        check_cfg("R1 reset", DEF_FRAME);
        chk("R1 dout", ser_dout, 1'b0);
    endtask

    task automatic t_write_basic;
        for (int i = 0; i < FW-1; i++) send_bit(W1[i]);
        wait_clk(6);
        check_cfg("R3 before 40th bit", DEF_FRAME);
        send_bit(W1[FW-1]); ser_clk = 1'b1; wait_clk(6);
        check_cfg("R3 write", W1);
        chk("R8 dout after frame", ser_dout, W1[0]);
    endtask

    task automatic t_idle_zeros;
        for (int i = 0; i < 5; i++) begin
            send_bit(1'b0);
            chk("R2 dout idle", ser_dout, W1[0]);
        end
        check_cfg("R2 cfg idle", W1);
        send_frame(W2);
        check_cfg("R2 aligned write", W2);
    endtask

    task automatic t_read_frame;
        send_frame(RD);
        check_cfg("R4 read keeps", W2);
        wait_clk(20);
        check_cfg("R10 quiet", W2);
    endtask

    task automatic t_route_ties;
        send_frame(W3);
        check_cfg("R7 ties", W3);
    endtask

    task automatic t_dout_order;
        send_frame(RA);
        check_cfg("R4 read A", W3);
        chk("R8 dout read D0", ser_dout, RA[0]);
        for (int k = 0; k < FW; k++) begin
            send_bit(W2[k]);
            if (k < FW-1) chk($sformatf("R8 dout bit %0d", k+1), ser_dout, RA[k+1]);
            else          chk("R8 dout new D0", ser_dout, W2[0]);
        end
        ser_clk = 1'b1; wait_clk(6);
        check_cfg("R8 write after read", W2);
    endtask

    task automatic t_cfg_reset;
        cfg_rst = 1'b1; wait_clk(10);
        cfg_rst = 1'b0; wait_clk(6);
        check_cfg("R9 pulse defaults", DEF_FRAME);
        cfg_rst = 1'b1; wait_clk(4);
        send_frame(W1);
        check_cfg("R9 blocked write", DEF_FRAME);
        cfg_rst = 1'b0; wait_clk(6);
        check_cfg("R9 after release", DEF_FRAME);
        send_frame(W3);
        check_cfg("R9 write resumes", W3);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset_defaults();
        t_write_basic();
        t_idle_zeros();
        t_read_frame();
        t_route_ties();
        t_dout_order();
        t_cfg_reset();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end
endmodule